// File: doc/BRIEF.md
# Byte-Wide Flash Bus Front-End Emulator

This block recreates, inside a clocked design, the asynchronous byte-wide bus of a sector-erase, byte-program nonvolatile memory. A host drives active-low chip-enable, write-enable and output-enable strobes together with an address and a data byte. The block passes the strobes through two-flop synchronisers and derives write cycles and read cycles from their combined edges. It decodes two-write program and erase commands and executes them on a small parameterised array.

Program and erase are gated by a software protection state. That state is switched by a fixed sequence of seven read cycles. While a program or erase is busy, reads return a status byte. In that byte one bit flips on every read cycle and one bit is the inverse of the byte being written. When the busy timer runs out, reads return array contents again. The array holds 2^MEM_AW bytes, and the low MEM_AW address bits select the byte. A sector is 256 bytes, selected by address bits [MEM_AW-1:8].

Top module: `flash_bus_emu`

## Requirements
- R1: After reset every array byte reads 0xFF, data_oe_o is 0, protection is off and the block is not busy.
- R2: A write cycle exists only while ce_ni and we_ni are both low. Its address is taken at the later of the two falling edges, and its data at the earlier of the two rising edges. A we_ni pulse with ce_ni high has no effect.
- R3: A write of 0x10 followed by a write of byte D at address A programs location A to (old value AND D).
- R4: A write of 0x20 followed by a write of 0xD0 sets to 0xFF every byte of the sector that holds the address of the 0xD0 write. Other sectors are unchanged.
- R5: A program stays busy for PROG_CYC cycles and an erase for ERASE_CYC cycles. While busy, a read returns bit 7 as the inverse of bit 7 of the byte being written (0xFF for erase), bits [5:0] as 0, and bit 6 inverted from its value in the previous busy read.
- R6: Once busy ends, reads return array contents.
- R7: Write cycles during busy are ignored and do not advance the command decoder.
- R8: Read cycles (ce_ni and oe_ni low, we_ni high) to 0x00A55, 0x05AA0, 0x00F0F, 0x0F0F0, 0x03C3C, 0x0C3C3 in that order, followed by a seventh read to 0x07E00, turn protection on. If the seventh read is to 0x007E0 instead, protection turns off. The address of each read is taken at the earlier of the oe_ni and ce_ni rising edges.
- R9: A read to any address other than the expected one returns the sequence to its first step.
- R10: While protection is on, write cycles are ignored.
- R11: data_oe_o is high during a read cycle, two clock cycles behind the strobes, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fabric clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ce_ni | input | 1 | chip enable, active low |
| we_ni | input | 1 | write enable, active low |
| oe_ni | input | 1 | output enable, active low |
| addr_i | input | ADDR_W | byte address |
| data_i | input | 8 | write data from host |
| data_o | output | 8 | read data or busy status |
| data_oe_o | output | 1 | drive enable for data_o |

## Verification
A wrong latch point in the write decoder places a byte at the wrong address. This shows on the next read of that location, at the latest after one busy period. A stuck busy timer or toggle flop is seen at once, within the first two status reads after a command. A matcher that skips or keeps a step shows as a program that is wrongly accepted or wrongly dropped, which the bench can tell apart at the first read after the write: a busy status byte differs from the unchanged 0xFF.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [1:0] {CMD_IDLE, CMD_PROG_ARM, CMD_ERASE_ARM} cmd_state_e;
  localparam int SEQ_STEPS = 6;  // matched steps before the final address
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b1;
        s2_q[g] <= 1'b1;
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fe_strobe.sv
module fe_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic we_i,
  input  logic oe_i,
  output logic wr_start_o,
  output logic wr_end_o,
  output logic rd_end_o,
  output logic rd_act_o
);
  logic wr_act, wr_q, rd_q;

  // combined strobes: last fall opens, first rise closes
  assign wr_act   = ~ce_i & ~we_i;
  assign rd_act_o = ~ce_i & ~oe_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act_o;
    end
  end

  assign wr_start_o = wr_act & ~wr_q;
  assign wr_end_o   = ~wr_act & wr_q;
  assign rd_end_o   = ~rd_act_o & rd_q;
endmodule

// File: rtl/fe_prot_seq.sv
module fe_prot_seq
  import flash_emu_pkg::*;
#(
  parameter int                            AW       = 19,
  parameter logic [SEQ_STEPS-1:0][AW-1:0]  SEQ_TBL  = '0,
  parameter logic [AW-1:0]                 EN_ADDR  = '0,
  parameter logic [AW-1:0]                 DIS_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_end_i,
  input  logic [AW-1:0] addr_i,
  output logic          prot_o,
  output logic [2:0]    step_o
);
  logic [2:0] step_q;
  logic       prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      prot_q <= 1'b0;
    end else if (rd_end_i) begin
      if (step_q == 3'(SEQ_STEPS)) begin
        step_q <= '0;
        if (addr_i == EN_ADDR)       prot_q <= 1'b1;
        else if (addr_i == DIS_ADDR) prot_q <= 1'b0;
      end else if (addr_i == SEQ_TBL[step_q]) begin
        step_q <= step_q + 3'd1;
      end else begin
        step_q <= '0;
      end
    end
  end

  assign prot_o = prot_q;
  assign step_o = step_q;
endmodule

// File: rtl/fe_store.sv
module fe_store #(
  parameter int MEM_AW    = 9,
  parameter int SECT_AW   = 8,
  parameter int PROG_CYC  = 1750,
  parameter int ERASE_CYC = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  input  logic              rd_end_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       stat_q;
  logic             tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_i) begin
      mem[waddr_i] <= mem[waddr_i] & wdata_i;  // cells only clear
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++)
        if ((i >> SECT_AW) == int'(waddr_i[MEM_AW-1:SECT_AW])) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stat_q <= 8'hFF;
      tgl_q  <= 1'b0;
    end else begin
      if (prog_i) begin
        cnt_q  <= CNT_W'(PROG_CYC);
        stat_q <= wdata_i;
      end else if (erase_i) begin
        cnt_q  <= CNT_W'(ERASE_CYC);
        stat_q <= 8'hFF;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (rd_end_i && busy_o) tgl_q <= ~tgl_q;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign rdata_o = busy_o ? {~stat_q[7], tgl_q, 6'b0} : mem[raddr_i];
endmodule

// File: rtl/flash_bus_emu.sv
module flash_bus_emu
  import flash_emu_pkg::*;
#(
  parameter int                              ADDR_W     = 19,
  parameter int                              MEM_AW     = 9,
  parameter int                              PROG_CYC   = 1750,
  parameter int                              ERASE_CYC  = 100000,
  parameter logic [7:0]                      CMD_PROG   = 8'h10,
  parameter logic [7:0]                      CMD_ERASE  = 8'h20,
  parameter logic [7:0]                      CMD_ERCONF = 8'hD0,
  parameter logic [SEQ_STEPS-1:0][ADDR_W-1:0] SEQ_TBL   = {19'h0C3C3, 19'h03C3C, 19'h0F0F0,
                                                           19'h00F0F, 19'h05AA0, 19'h00A55},
  parameter logic [ADDR_W-1:0]               EN_ADDR    = 19'h07E00,
  parameter logic [ADDR_W-1:0]               DIS_ADDR   = 19'h007E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  logic [2:0]        strb_s;
  logic              wr_start, wr_end, rd_end, rd_act;
  logic              prot_on, busy, prog_go, erase_go, wr_ok;
  logic [2:0]        seq_step;
  logic [MEM_AW-1:0] wr_addr_q;
  cmd_state_e        cmd_q;

  fe_sync #(.W(3)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({oe_ni, we_ni, ce_ni}), .q_o(strb_s)
  );

  fe_strobe u_strobe (
    .clk_i     (clk_i),     .rst_ni  (rst_ni),
    .ce_i      (strb_s[0]), .we_i    (strb_s[1]), .oe_i(strb_s[2]),
    .wr_start_o(wr_start),  .wr_end_o(wr_end),
    .rd_end_o  (rd_end),    .rd_act_o(rd_act)
  );

  fe_prot_seq #(
    .AW(ADDR_W), .SEQ_TBL(SEQ_TBL), .EN_ADDR(EN_ADDR), .DIS_ADDR(DIS_ADDR)
  ) u_prot (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_end_i(rd_end),
    .addr_i(addr_i), .prot_o(prot_on), .step_o(seq_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_addr_q <= '0;
    else if (wr_start) wr_addr_q <= addr_i[MEM_AW-1:0];
  end

  assign wr_ok    = wr_end & ~busy & ~prot_on;
  assign prog_go  = wr_ok & (cmd_q == CMD_PROG_ARM);
  assign erase_go = wr_ok & (cmd_q == CMD_ERASE_ARM) & (data_i == CMD_ERCONF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_IDLE;
    end else if (wr_ok) begin
      unique case (cmd_q)
        CMD_IDLE:
          if (data_i == CMD_PROG)       cmd_q <= CMD_PROG_ARM;
          else if (data_i == CMD_ERASE) cmd_q <= CMD_ERASE_ARM;
        default: cmd_q <= CMD_IDLE;
      endcase
    end
  end

  fe_store #(
    .MEM_AW(MEM_AW), .SECT_AW(8), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_store (
    .clk_i  (clk_i),     .rst_ni  (rst_ni),
    .prog_i (prog_go),   .erase_i (erase_go),
    .waddr_i(wr_addr_q), .wdata_i (data_i),
    .raddr_i(addr_i[MEM_AW-1:0]), .rd_end_i(rd_end),
    .rdata_o(data_o),    .busy_o  (busy)
  );

  assign data_oe_o = rd_act;
endmodule

// File: rtl/fe_chk.sv
module fe_chk #(
  parameter int ERASE_CYC = 100000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       oe_ni,
  input logic       data_oe_o,
  input logic       busy,
  input logic       wr_end,
  input logic       prot_on,
  input logic [1:0] cmd_state
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!$past(oe_ni, 2) && !$past(ce_ni, 2))); // R11

  AST_BUSY_HOLDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_end) |=> (cmd_state == $past(cmd_state))); // R7

  AST_PROT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(prot_on)); // R10

  AST_BUSY_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= ERASE_CYC); // R5
endmodule

bind flash_bus_emu fe_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
  .data_oe_o(data_oe_o), .busy(busy), .wr_end(wr_end),
  .prot_on(prot_on), .cmd_state(cmd_q)
);

// File: tb/sim_flash_bus_emu.sv
module sim_flash_bus_emu;
  localparam int PROG_T  = 150;
  localparam int ERASE_T = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  int          total = 0;
  int          bad = 0;

  logic [18:0] seq_a [6] = '{19'h00A55, 19'h05AA0, 19'h00F0F,
                              19'h0F0F0, 19'h03C3C, 19'h0C3C3};
  localparam logic [18:0] SEQ_EN  = 19'h07E00;
  localparam logic [18:0] SEQ_DIS = 19'h007E0;

  always #10 clk = ~clk;

  flash_bus_emu #(.PROG_CYC(PROG_T), .ERASE_CYC(ERASE_T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // we_first=1: WE falls first, CE falls last, CE rises first
  task automatic bus_wr(input logic [18:0] a, input logic [7:0] d, input bit we_first);
    addr = 19'h7FFFF; din = 8'h5A;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    cyc(4);
    addr = a;
    cyc(1);
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    cyc(4);
    addr = 19'h7FF00; din = d;
    cyc(4);
    if (we_first) ce_n = 1'b1; else we_n = 1'b1;
    cyc(4);
    din = ~d;
    cyc(2);
    ce_n = 1'b1; we_n = 1'b1;
    cyc(4);
  endtask

  task automatic bus_rd(input logic [18:0] a, output logic [7:0] d);
    addr = a;
    oe_n = 1'b0; ce_n = 1'b0;
    cyc(4);
    d = dout;
    chk("R11 oe during read", {7'b0, doe}, 8'h01);
    oe_n = 1'b1;
    cyc(4);
    ce_n = 1'b1;
    cyc(3);
    chk("R11 oe after read", {7'b0, doe}, 8'h00);
  endtask

  task automatic cmd_prog(input logic [18:0] a, input logic [7:0] d);
    bus_wr(a, 8'h10, 1'b0);
    bus_wr(a, d, 1'b1);
  endtask

  task automatic cmd_erase(input logic [18:0] a);
    bus_wr(a, 8'h20, 1'b1);
    bus_wr(a, 8'hD0, 1'b0);
  endtask

  task automatic prot_seq(input bit en);
    logic [7:0] t;
    for (int i = 0; i < 6; i++) bus_rd(seq_a[i], t);
    bus_rd(en ? SEQ_EN : SEQ_DIS, t);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 oe in reset", {7'b0, doe}, 8'h00);
    cyc(3); rst_n = 1'b1; cyc(3);
    chk("R1 oe after reset", {7'b0, doe}, 8'h00);
    bus_rd(19'h00000, v); chk("R1 byte 0x000", v, 8'hFF);
    bus_rd(19'h001FF, v); chk("R1 byte 0x1FF", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] s1, s2, v;
    cmd_prog(19'h00005, 8'h3C);
    bus_rd(19'h00005, s1);
    bus_rd(19'h00005, s2);
    chk("R5 prog status bit7", {7'b0, s1[7]}, {7'b0, ~1'b0});
    chk("R5 status low bits", {2'b0, s1[5:0]}, 8'h00);
    chk("R5 bit6 toggles", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    cyc(PROG_T + 20);
    bus_rd(19'h00005, v); chk("R3 R6 programmed byte", v, 8'h3C);
    cmd_prog(19'h00005, 8'hF0);
    cyc(PROG_T + 20);
    bus_rd(19'h00005, v); chk("R3 program clears only", v, 8'h30);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    // WE pulse with CE high must not arm a command
    addr = 19'h00030; din = 8'h10;
    we_n = 1'b0; cyc(6); we_n = 1'b1; cyc(4);
    bus_wr(19'h00030, 8'h00, 1'b0);
    cyc(10);
    bus_rd(19'h00030, v); chk("R2 we without ce ignored", v, 8'hFF);
    // both strobe orderings, address/data swapped outside their latch points
    bus_wr(19'h00031, 8'h10, 1'b1);
    bus_wr(19'h00031, 8'hA5, 1'b0);
    cyc(PROG_T + 20);
    bus_rd(19'h00031, v); chk("R2 latch points A", v, 8'hA5);
    bus_rd(19'h00100, v); chk("R2 junk address untouched", v, 8'hFF);
    bus_wr(19'h00032, 8'h10, 1'b0);
    bus_wr(19'h00032, 8'h69, 1'b1);
    cyc(PROG_T + 20);
    bus_rd(19'h00032, v); chk("R2 latch points B", v, 8'h69);
  endtask

  task automatic t_erase();
    logic [7:0] s, v;
    cmd_prog(19'h00150, 8'h00);
    cyc(PROG_T + 20);
    bus_rd(19'h00150, v); chk("R3 sector1 byte", v, 8'h00);
    cmd_erase(19'h001A0);
    bus_rd(19'h00150, s);
    chk("R5 erase status", {s[7], 1'b0, s[5:0]}, 8'h00);
    cyc(ERASE_T + 20);
    bus_rd(19'h00150, v); chk("R4 erased byte", v, 8'hFF);
    bus_rd(19'h00005, v); chk("R4 other sector kept", v, 8'h30);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    cmd_prog(19'h00010, 8'h55);
    cmd_prog(19'h00011, 8'h00);
    cyc(PROG_T + 40);
    bus_rd(19'h00011, v); chk("R7 write during busy ignored", v, 8'hFF);
    bus_rd(19'h00010, v); chk("R7 first program kept", v, 8'h55);
  endtask

  task automatic t_protect();
    logic [7:0] t, v;
    // broken sequence: protection must stay off
    bus_rd(seq_a[0], t); bus_rd(seq_a[1], t); bus_rd(seq_a[2], t);
    bus_rd(19'h00000, t);
    bus_rd(seq_a[3], t); bus_rd(seq_a[4], t); bus_rd(seq_a[5], t);
    bus_rd(SEQ_EN, t);
    cmd_prog(19'h00020, 8'h11);
    bus_rd(19'h00020, v); chk("R9 mismatch restarts, program busy", {7'b0, v[7]}, 8'h01);
    cyc(PROG_T + 20);
    bus_rd(19'h00020, v); chk("R9 program accepted", v, 8'h11);
    prot_seq(1'b1);
    cmd_prog(19'h00021, 8'h22);
    bus_rd(19'h00021, v); chk("R10 protected: no busy", v, 8'hFF);
    cyc(PROG_T + 20);
    bus_rd(19'h00021, v); chk("R8 R10 byte unchanged", v, 8'hFF);
    prot_seq(1'b0);
    cmd_prog(19'h00021, 8'h22);
    cyc(PROG_T + 20);
    bus_rd(19'h00021, v); chk("R8 unprotected program", v, 8'h22);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_edges();
    t_erase();
    t_busy_ignore();
    t_protect();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule